// File: doc/BRIEF.md
# Eight-Level Interrupt Controller

This block gathers eight interrupt request lines, keeps a pending bit for each, and drives one interrupt line toward a processor whenever an unmasked pending request outranks every level already being served. The processor answers with two acknowledge strobes. The first moves the winning level from pending to in-service. The second returns an 8-bit vector number built from a programmable base and the level number.

A small write port configures the block: per-line masks, vector base, per-line trigger style (edge or level), automatic rotation, and commands for end-of-interrupt and priority rotation. Priority is a ring of eight levels. A lowest-priority pointer decides where the ring starts. After reset the pointer is 7, which gives fixed order with level 0 on top.

The handshake runs on a two-state machine. `ST_IDLE` waits for the first acknowledge. The `ACK_FIRST` transition (ack in `ST_IDLE`) moves to `ST_ACK1` and latches the chosen level. In `ST_ACK1` the `ACK_SECOND` transition (ack again) emits the vector and returns to `ST_IDLE`. While the machine sits in `ST_ACK1`, the interrupt output is held low.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, int_out and vec_valid are 0 and vec_out is 0. All pending, in-service and mask bits are clear, all lines are edge-triggered, the vector base is 0 and the lowest-priority pointer is 7.
- R2: With no rotation, the lowest-numbered unmasked pending level wins.
- R3: A line whose mask bit is 1 (cfg_addr 0, bit i masks line i) never raises int_out and is never chosen.
- R4: int_out is 1 in `ST_IDLE` only when an unmasked pending level ranks strictly above every in-service level.
- R5: The first acknowledge sets the chosen level's in-service bit and clears its pending bit, and int_out is 0 in the following cycle.
- R6: After the second acknowledge, vec_out equals {base[7:3], level} and vec_valid is 1 for exactly one cycle. The base is written at cfg_addr 1, and its low three bits are ignored.
- R7: Command (cfg_addr 4, wdata[4:3]=00) clears the in-service bit of the highest-ranked in-service level.
- R8: Command wdata[4:3]=01 clears the in-service bit of level wdata[2:0].
- R9: An edge-triggered line (cfg_addr 2 bit i = 0) is latched only on a 0-to-1 change. A line held high after service makes no new request.
- R10: A level-triggered line (cfg_addr 2 bit i = 1) that drops before the first acknowledge cancels its request. A line still high after end-of-interrupt requests again.
- R11: With automatic rotation on (cfg_addr 3 bit 0 = 1), the level cleared by an end-of-interrupt becomes the lowest priority.
- R12: Command wdata[4:3]=10 makes level wdata[2:0] the lowest priority. The level after it in ring order becomes the highest.
- R13: An acknowledge pair with no winning request returns level 7 in the vector and changes no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, one per level |
| int_out | output | 1 | Interrupt line to the processor |
| ack | input | 1 | Acknowledge strobe, one cycle per pulse |
| vec_out | output | 8 | Vector number returned on the second acknowledge |
| vec_valid | output | 1 | One-cycle qualifier for vec_out |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration target: 0 mask, 1 base, 2 trigger, 3 mode, 4 command |
| cfg_wdata | input | 8 | Configuration write data |

## Verification
The bench exercises nesting. A lower level raised during service must stay silent, and a higher one must break through. A controller that compared against the wrong in-service level would interrupt too early or never. Non-specific end-of-interrupt is tested with two levels in service, so that clearing the wrong bit shows up as a premature interrupt. Edge and level triggers are compared by holding lines high across service and dropping them before acknowledge, which catches a latch that re-arms or fails to cancel. Rotation is checked with requests that straddle the ring start, and a spurious acknowledge pair must yield level 7 without blocking that level.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK1 = 1'b1
    } ack_state_t;

    typedef enum logic [2:0] {
        CFG_MASK = 3'd0,
        CFG_BASE = 3'd1,
        CFG_TRIG = 3'd2,
        CFG_MODE = 3'd3,
        CFG_CMD  = 3'd4
    } cfg_addr_t;

    typedef enum logic [1:0] {
        OP_EOI_HI  = 2'd0,
        OP_EOI_LVL = 2'd1,
        OP_SET_LOW = 2'd2,
        OP_NOP     = 2'd3
    } cmd_op_t;

endpackage

// File: rtl/irq_prio_pick.sv
// Picks the highest-ranked set bit on a ring whose lowest member is "lowest".
module irq_prio_pick #(
    parameter int LEVELS = 8,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [LEVELS-1:0] bits,
    input  logic [LVL_W-1:0]  lowest,
    output logic              found,
    output logic [LVL_W-1:0]  lvl,
    output logic [LVL_W-1:0]  rank
);
    always_comb begin
        int idx;
        found = 1'b0;
        lvl   = '0;
        rank  = '0;
        idx   = 0;
        // scan from worst rank to best so the best hit is written last
        for (int k = LEVELS - 1; k >= 0; k--) begin
            idx = (int'(lowest) + 1 + k) % LEVELS;
            if (bits[idx]) begin
                found = 1'b1;
                lvl   = LVL_W'(idx);
                rank  = LVL_W'(k);
            end
        end
    end
endmodule

// File: rtl/irq_req_latch.sv
// Pending-request register with per-line edge or level capture.
module irq_req_latch #(
    parameter int LEVELS = 8,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] irq_in,
    input  logic [LEVELS-1:0] level_mode,
    input  logic              clr_en,
    input  logic [LVL_W-1:0]  clr_lvl,
    output logic [LEVELS-1:0] irr
);
    logic [LEVELS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    for (genvar i = 0; i < LEVELS; i++) begin : g_line
        logic hit_clr;
        assign hit_clr = clr_en && (clr_lvl == LVL_W'(i));
        always_ff @(posedge clk) begin
            if (!rst_n)
                irr[i] <= 1'b0;
            else if (level_mode[i])
                irr[i] <= irq_in[i];
            else
                irr[i] <= (irr[i] & ~hit_clr) | (irq_in[i] & ~prev_q[i]);
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int LEVELS = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] irq_in,
    output logic              int_out,
    input  logic              ack,
    output logic [DATA_W-1:0] vec_out,
    output logic              vec_valid,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata
);
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int BASE_W = DATA_W - LVL_W;

    logic [LEVELS-1:0] irr, imr, trig_lvl, isr, isr_nxt;
    logic [BASE_W-1:0] base_q;
    logic              auto_rot;
    logic [LVL_W-1:0]  lowest_q, sel_lvl;
    ack_state_t        state_q, state_d;

    logic              cand_found, isr_found, int_req, take;
    logic [LVL_W-1:0]  cand_lvl, cand_rank, isr_lvl, isr_rank;
    logic              cmd_wr, eoi_do;
    cmd_op_t           cmd_op;
    logic [LVL_W-1:0]  cmd_arg, eoi_lvl;

    irq_prio_pick #(.LEVELS(LEVELS)) u_pick_req (
        .bits(irr & ~imr), .lowest(lowest_q),
        .found(cand_found), .lvl(cand_lvl), .rank(cand_rank)
    );

    irq_prio_pick #(.LEVELS(LEVELS)) u_pick_isr (
        .bits(isr), .lowest(lowest_q),
        .found(isr_found), .lvl(isr_lvl), .rank(isr_rank)
    );

    assign int_req = cand_found && (!isr_found || (cand_rank < isr_rank));
    assign take    = (state_q == ST_IDLE) && ack;

    irq_req_latch #(.LEVELS(LEVELS)) u_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(trig_lvl),
        .clr_en(take && int_req), .clr_lvl(cand_lvl), .irr(irr)
    );

    // command decode
    assign cmd_wr  = cfg_we && (cfg_addr == CFG_CMD);
    assign cmd_op  = cmd_op_t'(cfg_wdata[LVL_W+1:LVL_W]);
    assign cmd_arg = cfg_wdata[LVL_W-1:0];

    always_comb begin
        eoi_do  = 1'b0;
        eoi_lvl = isr_lvl;
        if (cmd_wr) begin
            unique case (cmd_op)
                OP_EOI_HI:  eoi_do = isr_found;
                OP_EOI_LVL: begin
                    eoi_do  = 1'b1;
                    eoi_lvl = cmd_arg;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        isr_nxt = isr;
        if (eoi_do)           isr_nxt[eoi_lvl]  = 1'b0;
        if (take && int_req)  isr_nxt[cand_lvl] = 1'b1;
    end

    // configuration and in-service state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr      <= '0;
            base_q   <= '0;
            trig_lvl <= '0;
            auto_rot <= 1'b0;
            lowest_q <= LVL_W'(LEVELS - 1);
            isr      <= '0;
        end else begin
            isr <= isr_nxt;
            if (cfg_we) begin
                if (cfg_addr == CFG_MASK) imr      <= cfg_wdata[LEVELS-1:0];
                if (cfg_addr == CFG_BASE) base_q   <= cfg_wdata[DATA_W-1:LVL_W];
                if (cfg_addr == CFG_TRIG) trig_lvl <= cfg_wdata[LEVELS-1:0];
                if (cfg_addr == CFG_MODE) auto_rot <= cfg_wdata[0];
            end
            if (cmd_wr && cmd_op == OP_SET_LOW)
                lowest_q <= cmd_arg;
            else if (eoi_do && auto_rot)
                lowest_q <= eoi_lvl;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ack) state_d = ST_ACK1;   // ACK_FIRST
            ST_ACK1: if (ack) state_d = ST_IDLE;   // ACK_SECOND
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_lvl   <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= 1'b0;
            if (take)
                sel_lvl <= int_req ? cand_lvl : LVL_W'(LEVELS - 1);
            if (state_q == ST_ACK1 && ack) begin
                vec_out   <= {base_q, sel_lvl};
                vec_valid <= 1'b1;
            end
        end
    end

    assign int_out = (state_q == ST_IDLE) && int_req;

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int LEVELS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              cfg_we,
    input logic              int_out,
    input logic              vec_valid,
    input logic [LEVELS-1:0] irr,
    input logic [LEVELS-1:0] imr,
    input logic [LEVELS-1:0] isr
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (isr == '0 && !vec_valid && !int_out));

    // R3
    int_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~imr) != '0));

    // R6
    vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack));

    // R5
    isr_grows_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(isr) > $past($countones(isr))) |-> $past(ack));

    // R7
    isr_shrinks_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(isr) < $past($countones(isr))) |-> $past(cfg_we));
endmodule

bind irq_ctrl irq_ctrl_chk #(.LEVELS(LEVELS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .cfg_we(cfg_we),
    .int_out(int_out), .vec_valid(vec_valid),
    .irr(irr), .imr(imr), .isr(isr)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       int_out;
    logic       ack = 1'b0;
    logic [7:0] vec_out;
    logic       vec_valid;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_out(int_out),
        .ack(ack), .vec_out(vec_out), .vec_valid(vec_valid),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    // fields: [23:16] mask, [15:8] lines, [7] rotate cmd, [6:4] lowest,
    //         [3] int expected, [2:0] level expected
    localparam logic [23:0] TBL [7] = '{
        24'h00280B,   // R2: levels 3,5 -> 3
        24'h08280D,   // R3: 3 masked -> 5
        24'hFF2800,   // R3: all masked -> none
        24'h00818F,   // R12: lowest 0, levels 0,7 -> 7
        24'h0011BC,   // R12: lowest 3, levels 0,4 -> 4
        24'h00800F,   // R2: single level 7
        24'h010309    // R3: 0 masked, levels 0,1 -> 1
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_in = '0; ack = 1'b0; cfg_we = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic cfg(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic ack_pulse();
        ack = 1'b1;
        step(1);
        ack = 1'b0;
    endtask

    // full acknowledge pair; checks int drop and returned vector
    task automatic serve(input string req, input logic [7:0] exp_vec);
        ack_pulse();
        chk("R5 int low after first ack", int_out, 0);
        ack_pulse();
        chk({req, " vec_valid"}, vec_valid, 1);
        chk({req, " vector"}, vec_out, exp_vec);
        step(1);
        chk("R6 vec_valid single cycle", vec_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 int_out", int_out, 0);
        chk("R1 vec_valid", vec_valid, 0);
        chk("R1 vec_out", vec_out, 0);

        // vector table
        for (int v = 0; v < 7; v++) begin
            logic [23:0] e;
            e = TBL[v];
            do_reset();
            cfg(3'd1, 8'h40);
            if (e[7]) cfg(3'd4, {3'b000, 2'b10, e[6:4]});
            cfg(3'd0, e[23:16]);
            irq_in = e[15:8];
            step(2);
            chk($sformatf("R2/R3/R12 row %0d int", v), int_out, e[3]);
            if (e[3]) serve($sformatf("R6 row %0d", v), {5'b01000, e[2:0]});
            irq_in = '0;
        end

        // nesting and end-of-interrupt, edge mode
        do_reset();
        cfg(3'd1, 8'h40);
        irq_in = 8'h20; step(2);
        chk("R4 int on idle", int_out, 1);
        serve("R6 lvl5", 8'h45);
        irq_in = 8'h00; step(1);
        irq_in = 8'h40; step(2);
        chk("R4 lower level blocked", int_out, 0);
        irq_in = 8'h44; step(2);
        chk("R4 higher level breaks in", int_out, 1);
        serve("R4 nested", 8'h42);
        cfg(3'd4, 8'h00);            // non-specific: clears 2, leaves 5
        step(1);
        chk("R7 highest cleared only", int_out, 0);
        cfg(3'd4, 8'h0D);            // specific level 5
        step(1);
        chk("R8 specific EOI", int_out, 1);
        serve("R8 level6", 8'h46);
        cfg(3'd4, 8'h00);
        step(2);
        chk("R9 held line no re-request", int_out, 0);
        irq_in = '0;

        // level mode
        do_reset();
        cfg(3'd1, 8'h40);
        cfg(3'd2, 8'hFF);
        irq_in = 8'h10; step(2);
        chk("R10 level request", int_out, 1);
        irq_in = 8'h00; step(2);
        chk("R10 dropped cancels", int_out, 0);
        irq_in = 8'h10; step(2);
        serve("R10 level4", 8'h44);
        cfg(3'd4, 8'h00);
        step(1);
        chk("R10 held line re-requests", int_out, 1);
        irq_in = '0;

        // automatic rotation; base low bits ignored
        do_reset();
        cfg(3'd1, 8'h47);
        cfg(3'd3, 8'h01);
        irq_in = 8'h01; step(2);
        serve("R6 base low bits ignored", 8'h40);
        irq_in = 8'h00;
        cfg(3'd4, 8'h00);
        irq_in = 8'h09; step(2);
        chk("R11 int", int_out, 1);
        serve("R11 rotated pick", 8'h43);
        irq_in = '0;

        // spurious acknowledge
        do_reset();
        cfg(3'd1, 8'h40);
        chk("R13 idle int", int_out, 0);
        ack_pulse();
        ack_pulse();
        chk("R13 spurious vector", vec_out, 8'h47);
        step(1);
        irq_in = 8'h80; step(2);
        chk("R13 level7 not blocked", int_out, 1);
        irq_in = '0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule